// File: doc/BRIEF.md
# Software-Managed Variable-Page Translation Buffer

This block is a fully associative address translation buffer of 64 entries whose contents are owned entirely by software. Software fills and inspects it through one operation port with three commands. A read returns one of the two words of an entry, a write replaces one of the two words of an entry, and a search reports which entry, if any, covers a given effective address. Nothing is ever loaded or evicted by the hardware itself.

Each entry has two 32-bit words. The tag word carries an effective page number, a 3-bit size code and a valid flag. The data word carries a real page number, execute and write permissions, a zone select and four storage attribute bits. The size code picks a page of 1 KB, 4 KB, 16 KB, 64 KB, 256 KB, 1 MB, 4 MB or 16 MB (codes 0 to 7). Code s compares address bits [31:10+2s], so every entry in the buffer can cover a different amount of memory.

A separate translate port takes an effective address with an access kind. One cycle later it returns a hit flag, the physical address, the zone select, the attributes and a permission fault flag. Both ports register their results, so every answer appears on the cycle after the request.

Top module: `vtlb_core`

## Requirements
- R1: After reset every entry reads as zero, so no entry is valid. rsp_valid, xl_done and all result outputs are 0 until a request arrives.
- R2: Each operation (op_code 0 read, 1 write, 2 search) raises rsp_valid in the cycle after op_valid. A read returns the word named by op_word_sel (0 tag, 1 data) of entry op_index on rsp_rdata.
- R3: A write with op_word_sel 0 stores op_wdata into the tag word of entry op_index, and with op_word_sel 1 into its data word. All 32 bits are kept and the other word stays unchanged.
- R4: An entry matches an address when tag bit 6 is set and the address agrees with tag bits [31:10] in every bit position at or above 10 + 2×size, where size is tag bits [9:7].
- R5: A search (effective address on op_wdata) returns rsp_found = 1 and the lowest matching index on rsp_index. If no entry matches it returns rsp_found = 0 and rsp_index = 0.
- R6: An entry whose valid bit (tag bit 6) is clear never matches, whatever its page number.
- R7: On a hit, xl_pa takes the data word's real page number (bits [31:10]) above the page boundary and xl_ea below it. When several entries match, the lowest index is used.
- R8: xl_fault is set on a hit when xl_is_write is set and data bit 8 (write permission) is clear, or when xl_is_fetch is set and data bit 9 (execute permission) is clear. A plain read never faults.
- R9: A translate that matches no entry returns xl_done = 1, xl_hit = 0, xl_pa = 0 and xl_fault = 0.
- R10: On a hit, xl_zone carries data bits [7:4] and xl_attr carries data bits [3:0] of the chosen entry.
- R11: A translate issued in the same cycle as a write sees the buffer contents from before that write. The write affects requests from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Software operation request |
| op_code | input | 2 | 0 read, 1 write, 2 search, 3 no operation |
| op_index | input | 6 | Entry index for read and write |
| op_word_sel | input | 1 | 0 tag word, 1 data word |
| op_wdata | input | 32 | Write data, or effective address for search |
| rsp_valid | output | 1 | Operation result valid |
| rsp_rdata | output | 32 | Word returned by a read |
| rsp_found | output | 1 | Search found a matching entry |
| rsp_index | output | 6 | Lowest matching index of a search |
| xl_valid | input | 1 | Translate request |
| xl_ea | input | 32 | Effective address to translate |
| xl_is_write | input | 1 | Access is a store |
| xl_is_fetch | input | 1 | Access is an instruction fetch |
| xl_done | output | 1 | Translate result valid |
| xl_hit | output | 1 | Translate found an entry |
| xl_pa | output | 32 | Physical address |
| xl_fault | output | 1 | Permission fault |
| xl_zone | output | 4 | Zone select of the hit entry |
| xl_attr | output | 4 | Storage attributes of the hit entry |

## Verification
Translations are tried against pages of 1 KB, 4 MB and 16 MB. Each page is probed with one address just inside its boundary and one just outside, which shows whether the compare width follows each entry's own size code. Searches use an address covered by two overlapping entries, an address covered by one, and an address covered by none, which separates lowest-index priority from mere hit detection. Loads, stores and fetches are aimed at pages with and without each permission. A write and a translate that arrive in the same cycle show which contents the translate uses.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

    localparam int WORD_W    = 32;
    localparam int PAGE_LSB  = 10;
    localparam int VPN_W     = WORD_W - PAGE_LSB;
    localparam int SIZE_W    = 3;

    // tag word layout
    localparam int TAG_VALID_BIT = 6;
    localparam int TAG_SIZE_LSB  = 7;

    // data word layout
    localparam int DAT_EXEC_BIT  = 9;
    localparam int DAT_WRITE_BIT = 8;
    localparam int DAT_ZONE_LSB  = 4;
    localparam int ZONE_W        = 4;
    localparam int ATTR_W        = 4;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_SEARCH = 2'd2,
        OP_NONE   = 2'd3
    } op_e;

    // ones at every page-number bit that takes part in the compare
    function automatic logic [VPN_W-1:0] page_mask(input logic [SIZE_W-1:0] sz);
        logic [VPN_W-1:0] m;
        m = '1;
        return m << {sz, 1'b0};
    endfunction

endpackage

// File: rtl/vtlb_match.sv
module vtlb_match
    import vtlb_pkg::*;
(
    input  logic [VPN_W-1:0]  vpn,
    input  logic [SIZE_W-1:0] size,
    input  logic              valid,
    input  logic [VPN_W-1:0]  ea_vpn,
    output logic              hit
);
    logic [VPN_W-1:0] diff;

    always_comb begin
        diff = (vpn ^ ea_vpn) & page_mask(size);
        hit  = valid && (diff == '0);
    end
endmodule

// File: rtl/vtlb_first.sv
module vtlb_first #(
    parameter int N    = 64,
    parameter int IDXW = $clog2(N)
) (
    input  logic [N-1:0]    vec,
    output logic            found,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDXW'(i);
        end
    end
endmodule

// File: rtl/vtlb_core.sv
module vtlb_core
    import vtlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic [IDX_W-1:0]  op_index,
    input  logic              op_word_sel,
    input  logic [WORD_W-1:0] op_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              rsp_found,
    output logic [IDX_W-1:0]  rsp_index,
    input  logic              xl_valid,
    input  logic [WORD_W-1:0] xl_ea,
    input  logic              xl_is_write,
    input  logic              xl_is_fetch,
    output logic              xl_done,
    output logic              xl_hit,
    output logic [WORD_W-1:0] xl_pa,
    output logic              xl_fault,
    output logic [ZONE_W-1:0] xl_zone,
    output logic [ATTR_W-1:0] xl_attr
);

    typedef struct packed {
        logic              rsp_valid;
        logic [WORD_W-1:0] rsp_rdata;
        logic              rsp_found;
        logic [IDX_W-1:0]  rsp_index;
        logic              xl_done;
        logic              xl_hit;
        logic [WORD_W-1:0] xl_pa;
        logic              xl_fault;
        logic [ZONE_W-1:0] xl_zone;
        logic [ATTR_W-1:0] xl_attr;
    } res_t;

    logic [WORD_W-1:0] tag_q  [ENTRIES];
    logic [WORD_W-1:0] tag_d  [ENTRIES];
    logic [WORD_W-1:0] data_q [ENTRIES];
    logic [WORD_W-1:0] data_d [ENTRIES];
    res_t              res_q, res_d;

    logic [ENTRIES-1:0] srch_hits, xl_hits;
    logic               srch_found, xl_found;
    logic [IDX_W-1:0]   srch_idx, xl_idx;

    // one comparator pair per entry: search path and translate path
    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        vtlb_match u_srch (
            .vpn    (tag_q[g][WORD_W-1:PAGE_LSB]),
            .size   (tag_q[g][TAG_SIZE_LSB +: SIZE_W]),
            .valid  (tag_q[g][TAG_VALID_BIT]),
            .ea_vpn (op_wdata[WORD_W-1:PAGE_LSB]),
            .hit    (srch_hits[g])
        );
        vtlb_match u_xl (
            .vpn    (tag_q[g][WORD_W-1:PAGE_LSB]),
            .size   (tag_q[g][TAG_SIZE_LSB +: SIZE_W]),
            .valid  (tag_q[g][TAG_VALID_BIT]),
            .ea_vpn (xl_ea[WORD_W-1:PAGE_LSB]),
            .hit    (xl_hits[g])
        );
    end

    vtlb_first #(.N(ENTRIES), .IDXW(IDX_W)) u_srch_first (
        .vec   (srch_hits),
        .found (srch_found),
        .idx   (srch_idx)
    );

    vtlb_first #(.N(ENTRIES), .IDXW(IDX_W)) u_xl_first (
        .vec   (xl_hits),
        .found (xl_found),
        .idx   (xl_idx)
    );

    always_comb begin
        logic [WORD_W-1:0] hit_tag;
        logic [WORD_W-1:0] hit_dat;
        logic [VPN_W-1:0]  keep;

        tag_d  = tag_q;
        data_d = data_q;
        res_d  = '0;

        // software operation port
        if (op_valid) begin
            res_d.rsp_valid = 1'b1;
            case (op_e'(op_code))
                OP_READ: begin
                    res_d.rsp_rdata = op_word_sel ? data_q[op_index] : tag_q[op_index];
                end
                OP_WRITE: begin
                    if (op_word_sel) data_d[op_index] = op_wdata;
                    else             tag_d[op_index]  = op_wdata;
                end
                OP_SEARCH: begin
                    res_d.rsp_found = srch_found;
                    res_d.rsp_index = srch_idx;
                end
                default: ;
            endcase
        end

        // translate port, always from the registered contents
        hit_tag = tag_q[xl_idx];
        hit_dat = data_q[xl_idx];
        keep    = page_mask(hit_tag[TAG_SIZE_LSB +: SIZE_W]);
        res_d.xl_done = xl_valid;
        if (xl_valid && xl_found) begin
            res_d.xl_hit   = 1'b1;
            res_d.xl_pa    = {(hit_dat[WORD_W-1:PAGE_LSB] & keep) |
                              (xl_ea[WORD_W-1:PAGE_LSB] & ~keep),
                              xl_ea[PAGE_LSB-1:0]};
            res_d.xl_fault = (xl_is_write && !hit_dat[DAT_WRITE_BIT]) ||
                             (xl_is_fetch && !hit_dat[DAT_EXEC_BIT]);
            res_d.xl_zone  = hit_dat[DAT_ZONE_LSB +: ZONE_W];
            res_d.xl_attr  = hit_dat[ATTR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end
        end else begin
            res_q  <= res_d;
            tag_q  <= tag_d;
            data_q <= data_d;
        end
    end

    assign rsp_valid = res_q.rsp_valid;
    assign rsp_rdata = res_q.rsp_rdata;
    assign rsp_found = res_q.rsp_found;
    assign rsp_index = res_q.rsp_index;
    assign xl_done   = res_q.xl_done;
    assign xl_hit    = res_q.xl_hit;
    assign xl_pa     = res_q.xl_pa;
    assign xl_fault  = res_q.xl_fault;
    assign xl_zone   = res_q.xl_zone;
    assign xl_attr   = res_q.xl_attr;

endmodule

// File: rtl/vtlb_core_chk.sv
module vtlb_core_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             rsp_valid,
    input logic             rsp_found,
    input logic [IDX_W-1:0] rsp_index,
    input logic             xl_valid,
    input logic [31:0]      xl_ea,
    input logic             xl_is_write,
    input logic             xl_is_fetch,
    input logic             xl_done,
    input logic             xl_hit,
    input logic [31:0]      xl_pa,
    input logic             xl_fault
);

    a_r2_rsp_follows_op: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> rsp_valid);

    a_r2_no_rsp_without_op: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !rsp_valid);

    a_r5_miss_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_found |-> rsp_index == '0);

    a_r7_offset_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid |=> (!xl_hit || xl_pa[9:0] == $past(xl_ea[9:0])));

    a_r8_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        xl_fault |-> xl_hit && xl_done);

    a_r8_load_never_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_valid && !xl_is_write && !xl_is_fetch) |=> !xl_fault);

    a_r9_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_done && !xl_hit) |-> (xl_pa == '0 && !xl_fault));

    a_r9_done_tracks_request: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid |=> xl_done);

endmodule

bind vtlb_core vtlb_core_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/vtlb_core_bench.sv
module vtlb_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'd0;
    logic [5:0]  op_index = '0;
    logic        op_word_sel = 1'b0;
    logic [31:0] op_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_found;
    logic [5:0]  rsp_index;
    logic        xl_valid = 1'b0;
    logic [31:0] xl_ea = '0;
    logic        xl_is_write = 1'b0;
    logic        xl_is_fetch = 1'b0;
    logic        xl_done;
    logic        xl_hit;
    logic [31:0] xl_pa;
    logic        xl_fault;
    logic [3:0]  xl_zone;
    logic [3:0]  xl_attr;

    int checks = 0;
    int errors = 0;

    always #2ns clk = ~clk;

    vtlb_core u_vtlb_core (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sw_op(input logic [1:0] code, input logic [5:0] idx,
                         input logic sel, input logic [31:0] wd);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_index = idx;
        op_word_sel = sel; op_wdata = wd;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic xlate(input logic [31:0] ea, input logic wr, input logic fe);
        @(negedge clk);
        xl_valid = 1'b1; xl_ea = ea; xl_is_write = wr; xl_is_fetch = fe;
        @(negedge clk);
        xl_valid = 1'b0; xl_is_write = 1'b0; xl_is_fetch = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 xl_done", 32'(xl_done), 0);
        chk("R1 xl_pa", xl_pa, 0);
        sw_op(2'd0, 6'd5, 1'b0, 0);
        chk("R1 tag reads zero", rsp_rdata, 0);
        chk("R2 read rsp_valid", 32'(rsp_valid), 1);
        sw_op(2'd2, 6'd0, 1'b0, 32'h0000_0000);
        chk("R1 search finds nothing", 32'(rsp_found), 0);
        xlate(32'h0000_0123, 1'b0, 1'b0);
        chk("R1 translate misses", 32'(xl_hit), 0);
    endtask

    task automatic t_rw;
        sw_op(2'd1, 6'd3, 1'b0, 32'hABCD_E7FF);
        sw_op(2'd1, 6'd3, 1'b1, 32'h5555_5AF3);
        sw_op(2'd0, 6'd3, 1'b0, 0);
        chk("R3 tag kept after data write", rsp_rdata, 32'hABCD_E7FF);
        sw_op(2'd0, 6'd3, 1'b1, 0);
        chk("R2 data word read", rsp_rdata, 32'h5555_5AF3);
        sw_op(2'd0, 6'd4, 1'b1, 0);
        chk("R3 neighbour untouched", rsp_rdata, 0);
        sw_op(2'd1, 6'd3, 1'b0, 32'h0000_0000);
    endtask

    task automatic t_sizes;
        sw_op(2'd1, 6'd10, 1'b0, 32'h0040_0340);
        sw_op(2'd1, 6'd10, 1'b1, 32'h8000_035A);
        xlate(32'h0077_1234, 1'b1, 1'b1);
        chk("R4 4MB page hit", 32'(xl_hit), 1);
        chk("R7 4MB address", xl_pa, 32'h8037_1234);
        chk("R8 permitted store no fault", 32'(xl_fault), 0);
        chk("R10 zone", 32'(xl_zone), 32'h5);
        chk("R10 attr", 32'(xl_attr), 32'hA);
        xlate(32'h0087_0000, 1'b1, 1'b0);
        chk("R4 outside 4MB page", 32'(xl_hit), 0);
        chk("R9 miss pa", xl_pa, 0);
        chk("R9 miss fault", 32'(xl_fault), 0);
        chk("R9 miss done", 32'(xl_done), 1);

        sw_op(2'd1, 6'd20, 1'b0, 32'h1000_0440);
        sw_op(2'd1, 6'd20, 1'b1, 32'h2000_0C00);
        xlate(32'h1000_07FF, 1'b0, 1'b0);
        chk("R4 1KB last byte hit", 32'(xl_hit), 1);
        chk("R7 1KB address", xl_pa, 32'h2000_0FFF);
        chk("R8 load no fault", 32'(xl_fault), 0);
        xlate(32'h1000_0800, 1'b0, 1'b0);
        chk("R4 next 1KB page misses", 32'(xl_hit), 0);
        xlate(32'h1000_0400, 1'b1, 1'b0);
        chk("R8 store without write perm", 32'(xl_fault), 1);
        xlate(32'h1000_0400, 1'b0, 1'b1);
        chk("R8 fetch without exec perm", 32'(xl_fault), 1);

        sw_op(2'd1, 6'd30, 1'b0, 32'hFF00_03C0);
        sw_op(2'd1, 6'd30, 1'b1, 32'h0100_01F1);
        xlate(32'hFFAB_CDEF, 1'b0, 1'b1);
        chk("R7 16MB address", xl_pa, 32'h01AB_CDEF);
        chk("R8 16MB fetch fault", 32'(xl_fault), 1);
        chk("R10 16MB zone", 32'(xl_zone), 32'hF);
        xlate(32'hFFAB_CDEF, 1'b1, 1'b0);
        chk("R8 16MB store allowed", 32'(xl_fault), 0);
        xlate(32'hFE00_0000, 1'b0, 1'b0);
        chk("R4 below 16MB page", 32'(xl_hit), 0);
    endtask

    task automatic t_search;
        sw_op(2'd1, 6'd12, 1'b0, 32'h0040_02C0);
        sw_op(2'd2, 6'd0, 1'b0, 32'h0041_0000);
        chk("R5 overlap found", 32'(rsp_found), 1);
        chk("R5 overlap lowest", 32'(rsp_index), 10);
        sw_op(2'd2, 6'd0, 1'b0, 32'h0060_0000);
        chk("R5 single match", 32'(rsp_index), 10);
        sw_op(2'd2, 6'd0, 1'b0, 32'hFF12_3456);
        chk("R5 16MB index", 32'(rsp_index), 30);
        sw_op(2'd2, 6'd0, 1'b0, 32'h3000_0000);
        chk("R5 none found", 32'(rsp_found), 0);
        chk("R5 none index", 32'(rsp_index), 0);
        xlate(32'h0041_0000, 1'b0, 1'b0);
        chk("R7 overlap uses lowest", xl_pa, 32'h8001_0000);
    endtask

    task automatic t_invalid;
        sw_op(2'd1, 6'd40, 1'b0, 32'h5000_0000);
        sw_op(2'd2, 6'd0, 1'b0, 32'h5000_0000);
        chk("R6 invalid entry ignored", 32'(rsp_found), 0);
        xlate(32'h5000_0010, 1'b0, 1'b0);
        chk("R6 invalid no translate", 32'(xl_hit), 0);
        sw_op(2'd1, 6'd40, 1'b0, 32'h5000_0040);
        sw_op(2'd2, 6'd0, 1'b0, 32'h5000_0000);
        chk("R6 valid entry found", 32'(rsp_index), 40);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'd1; op_index = 6'd40;
        op_word_sel = 1'b0; op_wdata = 32'h5000_0000;
        xl_valid = 1'b1; xl_ea = 32'h5000_0010;
        @(negedge clk);
        op_valid = 1'b0; xl_valid = 1'b0;
        chk("R11 translate sees old entry", 32'(xl_hit), 1);
        chk("R11 old entry address", xl_pa, 32'h0000_0010);
        xlate(32'h5000_0010, 1'b0, 1'b0);
        chk("R11 next cycle sees write", 32'(xl_hit), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rw();
        t_sizes();
        t_search();
        t_invalid();
        t_same_cycle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400us;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule